// File: doc/BRIEF.md
# High-Level Pulse Width Capture Timer

This block is one timer channel that measures how long an external, asynchronous input stays high. The width is counted in cycles of the count clock. Software, or a neighbouring controller, arms the channel with a one-cycle start request. The channel then waits for a rising edge on the input. That edge clears the counter to zero and starts it counting up. The next falling edge copies the counter into a capture register and raises a one-cycle interrupt pulse.

The input first passes through a synchronizer. An optional noise filter can follow it; the filter accepts a new level only once that level has held for two count-clock samples. After a capture the channel stays armed and freezes the counter until the next rising edge begins a new measurement. If the counter wraps during a measurement, an overflow flag is raised. A stop request disarms the channel, and edges are ignored until the channel is started again.

Top module: `hiwidth_capture`

## Requirements
- R1: While reset is asserted (rst_n low), enabled, count, capture, irq and ovf are all 0.
- R2: A start_req pulse makes enabled 1 from the next clock. A stop_req pulse makes enabled 0 from the next clock. When both are high in the same cycle, stop wins.
- R3: While enabled, the counter holds its value until a rising edge is detected. It is then loaded with 0 and increments by one per clock. With the filter off, count reads k-3 at the k-th clock after the pin rises (k >= 3).
- R4: A detected falling edge copies the counter into capture and pulses irq. For a pin high for H clocks, capture equals (H-1) mod 2^16. With the filter off, irq is high in the cycle that follows the 3rd clock edge after the pin falls.
- R5: irq is high for exactly one clock per capture and never occurs while the channel is disabled. capture changes only together with irq.
- R6: With filt_en = 1, both edges are detected 2 clocks later than without the filter, so irq follows the 5th clock edge after the pin falls. The measured width is unchanged. A pin pulse shorter than 2 clocks is ignored.
- R7: After a capture, enabled stays 1 and count holds the captured value until the next rising edge starts a new measurement.
- R8: If the counter wraps from FFFFh to 0000h before the falling edge, ovf becomes 1 and stays 1 until the next start trigger clears it.
- R9: While disabled, input edges are ignored: no irq is raised, and count and capture keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle arm strobe |
| stop_req | input | 1 | One-cycle disarm strobe |
| filt_en | input | 1 | 1 selects the noise-filtered input |
| tin | input | 1 | Asynchronous input whose high time is measured |
| enabled | output | 1 | Channel armed status |
| count | output | 16 | Running counter value |
| capture | output | 16 | Last captured width |
| irq | output | 1 | One-cycle capture pulse |
| ovf | output | 1 | Counter wrapped during the current or last measurement |

## Verification
The input crosses two synchronizer flops, and the edge is decoded combinationally from the synchronized level. As a result, the counter clears at the 3rd clock edge after the pin rises, and the capture lands at the 3rd edge after the pin falls; the filter adds 2 edges to both. The driver stamps each expected capture with the cycle number at which irq is due: the falling-drive cycle plus 3, or plus 5 with the filter. The monitor samples on the falling clock edge and checks the value, the overflow flag and that exact cycle. Mid-pulse counter checks and the status checks are also taken at falling edges, at a cycle count worked out from the same latencies.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } hwc_edge_t;
endpackage

// File: rtl/hwc_sync.sv
module hwc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hwc_filter.sv
module hwc_filter #(
  parameter int SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int HIST = SAMPLES - 1;

  logic [HIST-1:0] hist_q, hist_d;
  logic            lvl_q, lvl_d;
  logic            agree;

  generate
    if (HIST == 1) begin : g_one
      always_comb hist_d = d;
    end else begin : g_many
      always_comb hist_d = {hist_q[HIST-2:0], d};
    end
  endgenerate

  always_comb begin
    agree = d ? (&hist_q) : ~(|hist_q);
    lvl_d = agree ? d : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      lvl_q  <= lvl_d;
    end
  end

  assign q = lvl_q;
endmodule

// File: rtl/hwc_edge.sv
module hwc_edge
  import hwc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  output hwc_edge_t edges
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    edges.rise = lvl & ~prev_q;
    edges.fall = ~lvl & prev_q;
  end
endmodule

// File: rtl/hwc_core.sv
module hwc_core
  import hwc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  hwc_edge_t        edges,
  output logic             enabled,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             irq,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             en_q, en_d, run_q, run_d, irq_q, irq_d, ovf_q, ovf_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d;

  always_comb begin
    en_d  = en_q;
    run_d = run_q;
    cnt_d = cnt_q;
    cap_d = cap_q;
    ovf_d = ovf_q;
    irq_d = 1'b0;
    if (stop_req)       en_d = 1'b0;
    else if (start_req) en_d = 1'b1;
    if (stop_req) begin
      run_d = 1'b0;
    end else if (en_q && edges.rise) begin
      cnt_d = '0;
      run_d = 1'b1;
      ovf_d = 1'b0;
    end else if (run_q && edges.fall) begin
      cap_d = cnt_q;
      irq_d = 1'b1;
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q + CNT_ONE;
      if (cnt_q == CNT_MAX) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
      cap_q <= '0;
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      run_q <= run_d;
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      irq_q <= irq_d;
      ovf_q <= ovf_d;
    end
  end

  assign enabled = en_q;
  assign count   = cnt_q;
  assign capture = cap_q;
  assign irq     = irq_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/hiwidth_capture.sv
module hiwidth_capture
  import hwc_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             filt_en,
  input  logic             tin,
  output logic             enabled,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             irq,
  output logic             ovf
);
  logic      tin_s, tin_f, lvl;
  hwc_edge_t edges;

  hwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(tin), .q(tin_s)
  );

  hwc_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .d(tin_s), .q(tin_f)
  );

  assign lvl = filt_en ? tin_f : tin_s;

  hwc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .edges(edges)
  );

  hwc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .edges(edges), .enabled(enabled), .count(count), .capture(capture),
    .irq(irq), .ovf(ovf)
  );
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             stop_req,
  input logic             enabled,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capture,
  input logic             irq,
  input logic             ovf
);
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !stop_req) |=> enabled); // R2
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !enabled); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5
  AST_IRQ_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(enabled)); // R5
  AST_CAP_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(capture)); // R5
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !start_req) |=> $stable(count)); // R9
  AST_OVF_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(enabled)); // R8
endmodule

bind hiwidth_capture hwc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
  .enabled(enabled), .count(count), .capture(capture), .irq(irq), .ovf(ovf)
);

// File: tb/sim_hiwidth_capture.sv
module sim_hiwidth_capture;
  typedef struct {
    logic [15:0] cap;
    logic        ovf;
    int          due;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic filt_en = 1'b0, tin = 1'b0;
  logic enabled, irq, ovf;
  logic [15:0] count, capture;

  int   cyc = 0, checks = 0, errors = 0, lat = 3;
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hiwidth_capture u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .filt_en(filt_en), .tin(tin), .enabled(enabled), .count(count),
    .capture(capture), .irq(irq), .ovf(ovf)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(int h, logic ovf_exp, string tag);
    exp_t e;
    tin = 1'b1;
    repeat (h) @(negedge clk);
    tin = 1'b0;
    e.cap = 16'((h - 1) % 65536);
    e.ovf = ovf_exp;
    e.due = cyc + lat;
    e.tag = tag;
    exp_q.push_back(e);
    repeat (12) @(negedge clk);
  endtask

  task automatic strobe(logic s, logic p);
    start_req = s; stop_req = p;
    @(negedge clk);
    start_req = 1'b0; stop_req = 1'b0;
  endtask

  // monitor: each irq pops one expected capture
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected irq", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " capture"}, capture, e.cap);
        check({e.tag, " ovf"}, ovf, e.ovf);
        check({e.tag, " irq cycle"}, cyc, e.due);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] cap_keep, cnt_keep;
    repeat (3) @(negedge clk);
    check("R1 enabled", enabled, 0);
    check("R1 count", count, 0);
    check("R1 capture", capture, 0);
    check("R1 irq", irq, 0);
    check("R1 ovf", ovf, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    strobe(1'b1, 1'b0);
    check("R2 start", enabled, 1);
    repeat (4) @(negedge clk);
    check("R3 hold before rise", count, 0);

    // R3 counting mid-pulse, then R4 capture
    begin
      exp_t e;
      tin = 1'b1;
      repeat (10) @(negedge clk);
      check("R3 count mid-pulse", count, 7);
      repeat (10) @(negedge clk);
      tin = 1'b0;
      e.cap = 16'd19; e.ovf = 1'b0; e.due = cyc + lat; e.tag = "R4 width20";
      exp_q.push_back(e);
      repeat (12) @(negedge clk);
    end
    check("R7 count held", count, 19);
    check("R7 still enabled", enabled, 1);

    measure(1, 1'b0, "R4 width1");
    measure(2, 1'b0, "R4 width2");
    measure(5, 1'b0, "R7 width5");
    measure(300, 1'b0, "R4 width300");

    filt_en = 1'b1; lat = 5;
    repeat (4) @(negedge clk);
    measure(3, 1'b0, "R6 filt width3");
    tin = 1'b1; @(negedge clk); tin = 1'b0;
    repeat (12) @(negedge clk);
    check("R6 glitch ignored capture", capture, 2);
    check("R6 glitch ignored count", count, 2);
    measure(2, 1'b0, "R6 filt width2");
    filt_en = 1'b0; lat = 3;
    repeat (4) @(negedge clk);

    strobe(1'b0, 1'b1);
    check("R2 stop", enabled, 0);
    cap_keep = capture; cnt_keep = count;
    tin = 1'b1; repeat (10) @(negedge clk); tin = 1'b0;
    repeat (12) @(negedge clk);
    check("R9 capture kept", capture, cap_keep);
    check("R9 count kept", count, cnt_keep);

    strobe(1'b1, 1'b1);
    check("R2 stop wins", enabled, 0);
    strobe(1'b1, 1'b0);
    check("R2 restart", enabled, 1);

    measure(65538, 1'b1, "R8 wrap");
    check("R8 ovf sticky", ovf, 1);
    measure(4, 1'b0, "R8 ovf cleared");

    check("R4 all captures seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule